// File: doc/BRIEF.md
# Gated Receive Clock Generator

This block sits at the receive end of a bursty serial link. Received bits arrive in short bursts through a one-bit write port and are held in a 32-entry elastic buffer. The block drains that buffer through a synchronous serial output made of a generated bit clock and a data line. Every rising edge of the generated clock presents one valid buffered bit. When the buffer runs dry, the clock stops instead of producing edges with no data behind them. Packets with idle gaps between them can therefore be carried without the receiver seeing false bits.

The output period comes from a nominal divide ratio in system-clock cycles. At the start of every bit period the generator checks how full the buffer is and may trim that period by one system clock. A well-filled buffer gives a shorter period, and a nearly drained one gives a longer period. Over time the average output rate follows the rate at which the far end fills the buffer. While the level stays within the middle band no trim is applied, so corrections become rare once the level is steady.

A mode input picks synchronous operation. With it cleared, the generated clock is held off and the buffer is not drained. A write to a full buffer is dropped and raises a sticky error flag.

Top module: `rx_clkgen`

## Requirements
- R1: After reset, rx_clk and ovf_err are low and the buffer is empty.
- R2: From idle, a period starts only when sync_mode is high and at least 3 bits are buffered. Every period opens with its full low phase before the rising edge.
- R3: At each rising edge of rx_clk, rx_data carries the next buffered bit, in the order the bits were written. rx_data stays stable while rx_clk is high.
- R4: If the buffer is empty when a high phase ends, rx_clk stays low and no further rising edge occurs until R2 is met again.
- R5: While sync_mode is low, no new period starts and no bit is drained. A period already in progress completes, and no buffered bit is lost.
- R6: The nominal period P is max(div_ratio, 4) system clocks. The high phase lasts P - floor(P/2) cycles, and the low phase lasts floor(P/2) plus the correction.
- R7: The correction is taken from the buffer level when the period's bit is taken, before that bit is removed. It is -1 when the level is above 24, +1 when the level is below 8, and 0 otherwise.
- R8: A write while the buffer holds 32 bits is dropped and sets ovf_err. ovf_err stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Writes wr_bit into the buffer this cycle |
| wr_bit | input | 1 | Received data bit |
| div_ratio | input | 8 | Nominal output period in system clocks |
| sync_mode | input | 1 | 1 = synchronous output enabled, 0 = clock held off |
| rx_clk | output | 1 | Gated receive bit clock |
| rx_data | output | 1 | Receive data, valid at the rising edge of rx_clk |
| ovf_err | output | 1 | Sticky buffer overflow flag |

## Verification
The assertions assume that reset is applied before the first checked edge and that the buffer depth is a power of two. They also assume that div_ratio is not changed while a period is in progress, since the phase lengths are loaded from it. The stimulus changes div_ratio and the preloaded level only while sync_mode is low and the generator is idle. It drives writes and mode changes on falling clock edges. It stops writing once 32 bits are held, except in the one test that deliberately overflows the buffer.

// File: rtl/rx_clkgen.sv
module rx_clkgen #(
  parameter int DEPTH     = 32,
  parameter int DIV_W     = 8,
  parameter int START_MIN = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_valid,
  input  logic             wr_bit,
  input  logic [DIV_W-1:0] div_ratio,
  input  logic             sync_mode,
  output logic             rx_clk,
  output logic             rx_data,
  output logic             ovf_err
);

  localparam int AW      = $clog2(DEPTH);
  localparam int LW      = AW + 1;
  localparam int HI_MARK = (DEPTH * 3) / 4;
  localparam int LO_MARK = DEPTH / 4;
  localparam int MIN_DIV = 4;

  typedef enum logic [1:0] {S_IDLE, S_LOW, S_HIGH} state_t;

  state_t           state;
  logic [DIV_W-1:0] ph;
  logic [DEPTH-1:0] mem;
  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic [LW-1:0]    level;

  logic [DIV_W-1:0] div_eff, low_base, high_len, low_len;
  logic             push, pop, start, cont;

  assign div_eff  = (div_ratio < DIV_W'(MIN_DIV)) ? DIV_W'(MIN_DIV) : div_ratio;
  assign low_base = div_eff >> 1;
  assign high_len = div_eff - low_base;
  assign low_len  = (level > LW'(HI_MARK)) ? low_base - 1'b1 :
                    (level < LW'(LO_MARK)) ? low_base + 1'b1 : low_base;

  assign push  = wr_valid && (level != LW'(DEPTH));
  assign start = (state == S_IDLE) && sync_mode && (level >= LW'(START_MIN));
  assign cont  = (state == S_HIGH) && (ph == '0) && sync_mode && (level != '0);
  assign pop   = start || cont;

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= wr_bit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      level   <= '0;
      ovf_err <= 1'b0;
      rx_data <= 1'b0;
    end else begin
      if (push) wr_ptr <= wr_ptr + 1'b1;
      if (wr_valid && level == LW'(DEPTH)) ovf_err <= 1'b1;
      if (pop) begin
        rd_ptr  <= rd_ptr + 1'b1;
        rx_data <= mem[rd_ptr];
      end
      level <= level + LW'(push) - LW'(pop);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      ph     <= '0;
      rx_clk <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          state <= S_LOW;
          ph    <= low_len - 1'b1;
        end
        S_LOW: if (ph == '0) begin
          state  <= S_HIGH;
          rx_clk <= 1'b1;
          ph     <= high_len - 1'b1;
        end else begin
          ph <= ph - 1'b1;
        end
        S_HIGH: if (ph == '0) begin
          rx_clk <= 1'b0;
          if (cont) begin
            state <= S_LOW;
            ph    <= low_len - 1'b1;
          end else begin
            state <= S_IDLE;
          end
        end else begin
          ph <= ph - 1'b1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  logic [7:0] low_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                low_run <= '0;
    else if (rx_clk)           low_run <= '0;
    else if (low_run != 8'hff) low_run <= low_run + 1'b1;
  end

  p_start_min_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE && level < LW'(START_MIN)) |=> (state != S_LOW));

  p_low_phase_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_clk) |-> (low_run >= 8'd1));

  p_data_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_clk && $past(rx_clk)) |-> $stable(rx_data));

  p_stop_empty_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_HIGH && ph == '0 && level == '0) |=> (state == S_IDLE && !rx_clk));

  p_async_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!sync_mode && state == S_IDLE) |=> (state == S_IDLE && !rx_clk));

  p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_err |=> ovf_err);

  p_level_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    level <= LW'(DEPTH));

endmodule

// File: tb/rx_clkgen_tb.sv
module rx_clkgen_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_valid = 1'b0;
  logic       wr_bit = 1'b0;
  logic [7:0] div_ratio = 8'd8;
  logic       sync_mode = 1'b0;
  logic       rx_clk, rx_data, ovf_err;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int rise_cnt = 0;
  int low_run = 0;
  int rise_t [0:511];
  bit exp_q [$];
  logic rx_clk_d = 1'b0;

  always #10 clk = ~clk;

  rx_clkgen u_dut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_bit(wr_bit),
    .div_ratio(div_ratio), .sync_mode(sync_mode),
    .rx_clk(rx_clk), .rx_data(rx_data), .ovf_err(ovf_err)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // rising-edge monitor: data order (R3), minimum low phase (R2)
  always @(negedge clk) begin
    cyc++;
    if (rx_clk && !rx_clk_d) begin
      if (rise_cnt < 512) rise_t[rise_cnt] = cyc;
      rise_cnt++;
      check(low_run >= int'(div_ratio / 2) - 1, "R2 low phase", low_run, int'(div_ratio / 2) - 1);
      if (exp_q.size() == 0) begin
        check(1'b0, "R4 edge without data", 1, 0);
      end else begin
        bit e;
        e = exp_q.pop_front();
        check(rx_data == e, "R3 data", int'(rx_data), int'(e));
      end
    end
    if (!rx_clk) low_run++;
    else low_run = 0;
    rx_clk_d = rx_clk;
  end

  task automatic write_bit(input bit b, input bit keep);
    @(negedge clk);
    wr_valid = 1'b1;
    wr_bit   = b;
    if (keep) exp_q.push_back(b);
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic wait_rises(input int n, input int limit);
    int k;
    k = 0;
    while (rise_cnt < n && k < limit) begin
      @(negedge clk);
      k++;
    end
    check(rise_cnt >= n, "watch rises", rise_cnt, n);
  endtask

  // {div_ratio, preload level, expected interval between first two rises}
  localparam logic [23:0] VEC [0:5] = '{
    {8'd8,  8'd16, 8'd8},
    {8'd8,  8'd30, 8'd7},
    {8'd8,  8'd5,  8'd9},
    {8'd11, 8'd12, 8'd11},
    {8'd6,  8'd26, 8'd5},
    {8'd10, 8'd4,  8'd11}
  };

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int base;
    repeat (3) @(negedge clk);
    check(rx_clk == 1'b0, "R1 rx_clk", int'(rx_clk), 0);
    check(ovf_err == 1'b0, "R1 ovf_err", int'(ovf_err), 0);
    rst_n = 1'b1;
    sync_mode = 1'b1;
    repeat (20) @(negedge clk);
    check(rise_cnt == 0, "R1 empty after reset", rise_cnt, 0);

    // table of period corrections (R6, R7), each drained to a stop (R4)
    for (int v = 0; v < 6; v++) begin
      sync_mode = 1'b0;
      div_ratio = VEC[v][23:16];
      for (int i = 0; i < int'(VEC[v][15:8]); i++)
        write_bit(((i * 5 + v) % 3) == 0, 1'b1);
      base = rise_cnt;
      @(negedge clk);
      sync_mode = 1'b1;
      wait_rises(base + 2, 400);
      check(rise_t[base + 1] - rise_t[base] == int'(VEC[v][7:0]), "R7 R6 period",
            rise_t[base + 1] - rise_t[base], int'(VEC[v][7:0]));
      wait_rises(base + int'(VEC[v][15:8]), 2000);
      repeat (40) @(negedge clk);
      check(rise_cnt == base + int'(VEC[v][15:8]), "R4 stop when empty",
            rise_cnt - base, int'(VEC[v][15:8]));
      check(rx_clk == 1'b0, "R4 rx_clk low", int'(rx_clk), 0);
    end

    // start threshold (R2)
    div_ratio = 8'd8;
    sync_mode = 1'b1;
    base = rise_cnt;
    write_bit(1'b1, 1'b1);
    write_bit(1'b0, 1'b1);
    repeat (60) @(negedge clk);
    check(rise_cnt == base, "R2 two bits no clock", rise_cnt - base, 0);
    write_bit(1'b1, 1'b1);
    wait_rises(base + 3, 200);
    repeat (40) @(negedge clk);
    check(rise_cnt == base + 3, "R2 R4 three bits then stop", rise_cnt - base, 3);

    // asynchronous mode holds clock off and keeps data (R5)
    sync_mode = 1'b0;
    base = rise_cnt;
    for (int i = 0; i < 10; i++) write_bit(i[0] ^ i[2], 1'b1);
    repeat (80) @(negedge clk);
    check(rise_cnt == base, "R5 no edges in async", rise_cnt - base, 0);
    check(rx_clk == 1'b0, "R5 rx_clk low", int'(rx_clk), 0);
    sync_mode = 1'b1;
    wait_rises(base + 10, 400);
    repeat (30) @(negedge clk);
    check(rise_cnt == base + 10, "R5 bits kept", rise_cnt - base, 10);

    // mode cleared mid-stream: current period completes, nothing lost (R5)
    sync_mode = 1'b0;
    base = rise_cnt;
    for (int i = 0; i < 20; i++) write_bit(i[1], 1'b1);
    sync_mode = 1'b1;
    wait_rises(base + 3, 200);
    sync_mode = 1'b0;
    repeat (40) @(negedge clk);
    check(rise_cnt <= base + 4, "R5 stop mid-stream", rise_cnt - base, 4);
    check(rx_clk == 1'b0, "R5 held low", int'(rx_clk), 0);
    sync_mode = 1'b1;
    wait_rises(base + 20, 600);
    repeat (30) @(negedge clk);
    check(exp_q.size() == 0, "R5 no bit lost", exp_q.size(), 0);

    // overflow: 33rd write dropped, sticky flag (R8)
    sync_mode = 1'b0;
    base = rise_cnt;
    for (int i = 0; i < 32; i++) write_bit((i % 3) == 1, 1'b1);
    check(ovf_err == 1'b0, "R8 no flag at full", int'(ovf_err), 0);
    write_bit(1'b1, 1'b0);
    @(negedge clk);
    check(ovf_err == 1'b1, "R8 flag set", int'(ovf_err), 1);
    sync_mode = 1'b1;
    wait_rises(base + 32, 2000);
    repeat (40) @(negedge clk);
    check(rise_cnt == base + 32, "R8 dropped write", rise_cnt - base, 32);
    check(ovf_err == 1'b1, "R8 sticky", int'(ovf_err), 1);
    rst_n = 1'b0;
    @(negedge clk);
    check(ovf_err == 1'b0, "R1 R8 reset clears", int'(ovf_err), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule